// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Unit

This unit turns a "store bytes" request into a single aligned write beat for a big-endian memory. A request carries a byte address, a register value, a fill direction and a unit size (32-bit word or 64-bit doubleword). The unit produces the aligned address, the write data on the correct byte lanes, and one byte enable per lane.

In begin-fill mode the enabled bytes run from the addressed byte to the end of the aligned unit. In end-fill mode they run from the start of the unit up to, but not including, the addressed byte. Because memory is big-endian, the value's bytes already sit on the lanes they belong to once the value is placed in its natural position on the bus. The unit therefore only has to select lanes and clear the rest. Stores of 3, 5, 6 or 7 bytes leave as one beat, so the memory sees them as one indivisible write.

An end-fill request whose offset is zero writes no byte. It still goes out as a beat with all enables low and a probe flag set, so that write permission is checked and the line is marked dirty. The outputs are registered behind a valid/ready handshake.

Top module: `psb_store_lanes`

## Requirements
- R1: The output address is the input address with bits [1:0] cleared for a word request, or bits [2:0] cleared for a doubleword request; the higher bits are unchanged.
- R2: Begin-fill mode (in_fill_end=0) with offset k enables unit lanes k through U-1. U is 4 for a word and 8 for a doubleword; k is address bits [1:0] for a word or [2:0] for a doubleword.
- R3: End-fill mode (in_fill_end=1) with offset k enables unit lanes 0 through k-1. No lane is enabled when k is 0.
- R4: out_probe is 1 exactly when the beat is end-fill with offset 0, and out_be is then all zero. Every other beat has out_probe 0 and at least one enable set.
- R5: Lane L (address offset L, 0 = lowest address) is out_data bits [8*(7-L)+7 : 8*(7-L)] and is enabled by out_be[7-L]. A doubleword places in_value[63:0] on out_data[63:0]. A word places in_value[31:0] on out_data[63:32]. Every byte whose enable is 0 reads as zero.
- R6: For a word request, out_be[3:0] and out_data[31:0] are zero.
- R7: Each accepted request produces exactly one output beat, including the 3, 5, 6 and 7 byte stores.
- R8: A request is accepted on a clock edge where in_valid and in_ready are both 1, and in_ready = !out_valid || out_ready. While out_valid is 1 and out_ready is 0, every output holds its value.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | ADDR_W (32) | Byte address of the store |
| in_value | input | 8*BUS_BYTES (64) | Register value to store |
| in_fill_end | input | 1 | 0 = begin-fill, 1 = end-fill |
| in_dword | input | 1 | 0 = word unit, 1 = doubleword unit |
| out_valid | output | 1 | Write beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | ADDR_W (32) | Aligned address |
| out_data | output | 8*BUS_BYTES (64) | Lane-placed write data |
| out_be | output | BUS_BYTES (8) | Per-lane byte enable |
| out_probe | output | 1 | Permission probe only, nothing written |

## Verification
The bench builds the unit with its defaults: a 32-bit address, an 8-lane bus and a 4-byte word unit. With these values every word offset (0 to 3) and every doubleword offset (0 to 7) can be tested in both fill directions, so all the odd-sized 3, 5, 6 and 7 byte masks and the empty probe beat are covered. It also runs with word addresses that have bit 2 set, which shows that a word alignment clears only two bits. Directed tests hold out_ready low to exercise the back-pressure path and check that exactly one beat comes out per accepted request.

// File: rtl/psb_pkg.sv
package psb_pkg;
  // Fill direction of a partial store
  typedef enum logic {
    FILL_FROM_OFS = 1'b0,  // addressed byte up to the end of the unit
    FILL_UP_TO_OFS = 1'b1  // start of the unit up to the addressed byte
  } fill_e;
endpackage

// File: rtl/psb_lane_mask.sv
module psb_lane_mask #(
  parameter int BUS_BYTES  = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFS_W = $clog2(BUS_BYTES)
) (
  input  logic [OFS_W-1:0]     ofs,
  input  logic                 dword,
  input  psb_pkg::fill_e       fill,
  output logic [BUS_BYTES-1:0] be,
  output logic                 probe
);
  logic [OFS_W:0] unit_lim;
  logic [OFS_W:0] ofs_x;

  always_comb begin
    unit_lim = dword ? (OFS_W+1)'(BUS_BYTES) : (OFS_W+1)'(WORD_BYTES);
    ofs_x    = {1'b0, ofs};
    probe    = (fill == psb_pkg::FILL_UP_TO_OFS) && (ofs == '0);
  end

  // Enable bit b drives lane BUS_BYTES-1-b (lane 0 is the most significant byte)
  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
    localparam logic [OFS_W:0] LANE = (OFS_W+1)'(BUS_BYTES - 1 - b);
    always_comb begin
      if (fill == psb_pkg::FILL_FROM_OFS) be[b] = (LANE >= ofs_x) && (LANE < unit_lim);
      else                                be[b] = (LANE < ofs_x);
    end
  end
endmodule

// File: rtl/psb_lane_data.sv
module psb_lane_data #(
  parameter int BUS_BYTES  = 8,
  parameter int WORD_BYTES = 4,
  localparam int DATA_W = 8 * BUS_BYTES,
  localparam int WORD_W = 8 * WORD_BYTES
) (
  input  logic [DATA_W-1:0]    value,
  input  logic                 dword,
  input  logic [BUS_BYTES-1:0] be,
  output logic [DATA_W-1:0]    data
);
  logic [DATA_W-1:0] placed;

  // Big-endian: natural placement already lines bytes up with their lanes
  always_comb begin
    if (dword) placed = value;
    else       placed = {value[WORD_W-1:0], {(DATA_W-WORD_W){1'b0}}};
  end

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_byte
    assign data[8*b +: 8] = be[b] ? placed[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/psb_out_stage.sv
module psb_out_stage #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  localparam int DATA_W = 8 * BUS_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    nx_addr,
  input  logic [DATA_W-1:0]    nx_data,
  input  logic [BUS_BYTES-1:0] nx_be,
  input  logic                 nx_probe,
  input  logic                 nx_dword,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ADDR_W-1:0]    out_addr,
  output logic [DATA_W-1:0]    out_data,
  output logic [BUS_BYTES-1:0] out_be,
  output logic                 out_probe,
  output logic                 out_dword
);
  logic load_en;
  logic valid_d;

  always_comb begin
    in_ready = !out_valid || out_ready;
    load_en  = in_valid && in_ready;
    if (load_en)        valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  // Datapath registers: no reset, written only under the clock enable
  always_ff @(posedge clk) begin
    if (load_en) begin
      out_addr  <= nx_addr;
      out_data  <= nx_data;
      out_be    <= nx_be;
      out_probe <= nx_probe;
      out_dword <= nx_dword;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)
                                && $stable(out_be) && $stable(out_probe));

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_probe_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_probe |-> out_be == '0);

  p_beat_has_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_probe |-> out_be != '0);

  p_addr_word_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[1:0] == 2'b00);

  p_addr_dword_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dword |-> out_addr[2:0] == 3'b000);

  p_word_low_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dword |-> out_be[BUS_BYTES/2-1:0] == '0 && out_data[DATA_W/2-1:0] == '0);

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_chk
    p_off_lane_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_be[b] |-> out_data[8*b +: 8] == 8'h00);
  end
endmodule

// File: rtl/psb_store_lanes.sv
module psb_store_lanes #(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 8,
  parameter int WORD_BYTES = 4,
  localparam int DATA_W = 8 * BUS_BYTES,
  localparam int OFS_W  = $clog2(BUS_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [DATA_W-1:0]    in_value,
  input  logic                 in_fill_end,
  input  logic                 in_dword,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ADDR_W-1:0]    out_addr,
  output logic [DATA_W-1:0]    out_data,
  output logic [BUS_BYTES-1:0] out_be,
  output logic                 out_probe
);
  localparam logic [OFS_W-1:0]  WORD_OFS_MASK  = OFS_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] WORD_ADDR_MASK = ~ADDR_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] BUS_ADDR_MASK  = ~ADDR_W'(BUS_BYTES - 1);

  logic [OFS_W-1:0]     ofs;
  logic [ADDR_W-1:0]    addr_al;
  logic [BUS_BYTES-1:0] be_c;
  logic                 probe_c;
  logic [DATA_W-1:0]    data_c;
  logic                 dword_q;
  psb_pkg::fill_e       fill;

  always_comb begin
    fill    = psb_pkg::fill_e'(in_fill_end);
    ofs     = in_addr[OFS_W-1:0] & (in_dword ? {OFS_W{1'b1}} : WORD_OFS_MASK);
    addr_al = in_addr & (in_dword ? BUS_ADDR_MASK : WORD_ADDR_MASK);
  end

  psb_lane_mask #(.BUS_BYTES(BUS_BYTES), .WORD_BYTES(WORD_BYTES)) u_mask (
    .ofs(ofs), .dword(in_dword), .fill(fill), .be(be_c), .probe(probe_c)
  );

  psb_lane_data #(.BUS_BYTES(BUS_BYTES), .WORD_BYTES(WORD_BYTES)) u_data (
    .value(in_value), .dword(in_dword), .be(be_c), .data(data_c)
  );

  psb_out_stage #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .nx_addr(addr_al), .nx_data(data_c), .nx_be(be_c), .nx_probe(probe_c),
    .nx_dword(in_dword),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .out_be(out_be),
    .out_probe(out_probe), .out_dword(dword_q)
  );

  p_reset_idle_r9: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);

  // One accepted request yields one beat: with the consumer taking it and no new request, valid drops
  p_single_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: tb/psb_store_lanes_tb.sv
module psb_store_lanes_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;
  // [15]=end-fill, [14]=doubleword, [13:11]=offset, [8]=probe, [7:0]=expected enables
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0,1'b0,3'd0,2'b00,1'b0,8'hF0}, {1'b0,1'b0,3'd1,2'b00,1'b0,8'h70},
    {1'b0,1'b0,3'd2,2'b00,1'b0,8'h30}, {1'b0,1'b0,3'd3,2'b00,1'b0,8'h10},
    {1'b1,1'b0,3'd0,2'b00,1'b1,8'h00}, {1'b1,1'b0,3'd1,2'b00,1'b0,8'h80},
    {1'b1,1'b0,3'd2,2'b00,1'b0,8'hC0}, {1'b1,1'b0,3'd3,2'b00,1'b0,8'hE0},
    {1'b0,1'b1,3'd0,2'b00,1'b0,8'hFF}, {1'b0,1'b1,3'd1,2'b00,1'b0,8'h7F},
    {1'b0,1'b1,3'd2,2'b00,1'b0,8'h3F}, {1'b0,1'b1,3'd3,2'b00,1'b0,8'h1F},
    {1'b0,1'b1,3'd4,2'b00,1'b0,8'h0F}, {1'b0,1'b1,3'd5,2'b00,1'b0,8'h07},
    {1'b0,1'b1,3'd6,2'b00,1'b0,8'h03}, {1'b0,1'b1,3'd7,2'b00,1'b0,8'h01},
    {1'b1,1'b1,3'd0,2'b00,1'b1,8'h00}, {1'b1,1'b1,3'd1,2'b00,1'b0,8'h80},
    {1'b1,1'b1,3'd2,2'b00,1'b0,8'hC0}, {1'b1,1'b1,3'd3,2'b00,1'b0,8'hE0},
    {1'b1,1'b1,3'd4,2'b00,1'b0,8'hF0}, {1'b1,1'b1,3'd5,2'b00,1'b0,8'hF8},
    {1'b1,1'b1,3'd6,2'b00,1'b0,8'hFC}, {1'b1,1'b1,3'd7,2'b00,1'b0,8'hFE}
  };

  logic        clk, rst_n;
  logic        in_valid, in_ready, in_fill_end, in_dword;
  logic [31:0] in_addr;
  logic [63:0] in_value;
  logic        out_valid, out_ready, out_probe;
  logic [31:0] out_addr;
  logic [63:0] out_data;
  logic [7:0]  out_be;
  int checks, errors;

  psb_store_lanes u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_value(in_value), .in_fill_end(in_fill_end), .in_dword(in_dword),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .out_be(out_be), .out_probe(out_probe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Byte-array reference: lane L of the bus is byte L of the aligned unit
  function automatic logic [63:0] ref_data(input logic [63:0] val, input logic dw, input logic [7:0] be);
    logic [7:0] lanes [8];
    logic [63:0] r;
    for (int l = 0; l < 8; l++) lanes[l] = 8'h00;
    if (dw) for (int l = 0; l < 8; l++) lanes[l] = val[8*(7-l) +: 8];
    else    for (int l = 0; l < 4; l++) lanes[l] = val[8*(3-l) +: 8];
    r = '0;
    for (int l = 0; l < 8; l++) if (be[7-l]) r[8*(7-l) +: 8] = lanes[l];
    return r;
  endfunction

  task automatic drive(input logic [31:0] a, input logic [63:0] v, input logic e, input logic d);
    in_addr = a; in_value = v; in_fill_end = e; in_dword = d; in_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, ea, a_a, a_b;
    logic [63:0] v, v_a, v_b;
    logic        e, d;
    checks = 0; errors = 0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_addr = '0; in_value = '0; in_fill_end = 1'b0; in_dword = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", 64'(out_valid), 64'd0);
    check("R9 in_ready after reset", 64'(in_ready), 64'd1);

    for (int i = 0; i < NVEC; i++) begin
      e = VEC[i][15];
      d = VEC[i][14];
      a = (32'h8000_0100 | (32'(i) << 4)) | 32'(VEC[i][13:11]);
      if (!d && i[0]) a = a | 32'h4;
      v = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1010_2020_3030_4040);
      ea = d ? (a & ~32'h7) : (a & ~32'h3);
      drive(a, v, e, d);
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 beat present", 64'(out_valid), 64'd1);
      check("R1 aligned address", 64'(out_addr), 64'(ea));
      if (e) check("R3 end-fill enables", 64'(out_be), 64'(VEC[i][7:0]));
      else   check("R2 begin-fill enables", 64'(out_be), 64'(VEC[i][7:0]));
      check("R4 probe flag", 64'(out_probe), 64'(VEC[i][8]));
      check("R5 lane data", out_data, ref_data(v, d, VEC[i][7:0]));
      if (!d) check("R6 word low half idle", {out_data[31:0], 24'h0, out_be[3:0]}, 64'd0);
    end
    @(negedge clk);
    check("R7 no extra beat", 64'(out_valid), 64'd0);

    // Back-pressure: A held, B blocked until the consumer is ready
    a_a = 32'h0000_2005; v_a = 64'h1122_3344_5566_7788;
    a_b = 32'h0000_3003; v_b = 64'h99AA_BBCC_DDEE_FF01;
    out_ready = 1'b0;
    drive(a_a, v_a, 1'b1, 1'b1);
    @(negedge clk);
    drive(a_b, v_b, 1'b0, 1'b0);
    check("R8 in_ready low while stalled", 64'(in_ready), 64'd0);
    @(negedge clk);
    check("R8 hold valid", 64'(out_valid), 64'd1);
    check("R8 hold address", 64'(out_addr), 64'h0000_2000);
    check("R8 hold enables", 64'(out_be), 64'hF8);
    check("R8 hold data", out_data, 64'h1122_3344_5500_0000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next request taken", 64'(out_addr), 64'h0000_3000);
    check("R2 word offset 3 single lane", 64'(out_be), 64'h10);
    check("R5 word offset 3 data", out_data, 64'h0000_0001_0000_0000);
    @(negedge clk);
    check("R7 single beat after stall", 64'(out_valid), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule